// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounder

This block takes an unpacked floating-point mantissa and rounds it to its final precision. The two lowest bits of the incoming mantissa are the guard bit (upper) and the round bit (lower). A separate sticky bit summarises everything shifted out earlier. The block discards the guard and round bits by shifting right two places. It then adds one to what remains when the selected rounding mode and the sign of the value call for it. It supports round-to-nearest with ties to even, round toward zero, and two sign-dependent directed modes toward minus and plus infinity.

Each accepted operand produces one registered result a cycle later. The result carries the rounded mantissa, a flag saying whether the increment was applied, and an inexact flag. The output mantissa is one bit wider than the kept part of the input, so a carry that ripples out of an all-ones mantissa appears as a value of 2.0. The consumer can recognise that case from the rounded-up flag and the top bit, and renormalise. Exponent adjustment and exception handling stay with the consumer.

Top module: `mant_rounder`

## Requirements
- R1: With MANT_W input bits, out_mant is MANT_W-1 bits wide and equals in_mant[MANT_W-1:2] zero-extended by one bit plus one when an increment is applied. A carry out of the kept bits lands in the top bit (value 2.0) and is not corrected.
- R2: When in_mant[1] (guard), in_mant[0] (round) and in_sticky are all zero, no increment is applied and out_inexact is 0, in every mode and for either sign.
- R3: When any of guard, round or sticky is 1, out_inexact is 1, whatever the mode and sign.
- R4: In mode 2'b00 (nearest), an increment is applied only when guard is 1 and at least one of round, sticky, or in_mant[2] (the kept LSB) is 1. An exact tie therefore rounds to an even result.
- R5: In mode 2'b01 (toward zero), no increment is ever applied.
- R6: In mode 2'b10 (toward minus infinity), an increment is applied exactly when the result is inexact and in_sign is 1 (negative).
- R7: In mode 2'b11 (toward plus infinity), an increment is applied exactly when the result is inexact and in_sign is 0 (positive).
- R8: out_round_up is 1 exactly when the increment was applied to the result it accompanies.
- R9: out_valid is 1 in the cycle after each cycle with in_valid high and 0 otherwise. Cycles with in_valid low leave out_mant, out_round_up and out_inexact unchanged.
- R10: While rst is high and after it is released, out_valid, out_round_up, out_inexact and out_mant are all zero until the first accepted operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe; the operand is taken on this cycle's edge |
| in_mant | input | MANT_W | Unpacked mantissa; bit 1 is guard, bit 0 is round |
| in_sticky | input | 1 | OR of all bits shifted out before this block |
| in_sign | input | 1 | Sign of the value, 1 means negative |
| in_mode | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_mant | output | MANT_W-1 | Rounded mantissa including the carry bit |
| out_round_up | output | 1 | The increment was applied |
| out_inexact | output | 1 | Guard, round or sticky was nonzero |

## Verification
The interesting collision is a round-up decision that coincides with a carry rippling through every bit of the kept mantissa. The bench provokes it with all-ones kept fields under nearest and under the directed modes. It expects a lone top bit, the rounded-up flag and the inexact flag together in the same result. A second collision is the tie case, where the nearest decision hangs on the kept LSB that the increment itself would change. The bench drives exact ties with even and odd LSBs back to back and compares each against a model computed from the mode table. Random operands across all four modes and both signs then run through the same scoreboard.

// File: rtl/mrnd_pkg.sv
package mrnd_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_TO_ZERO = 2'b01,
    RM_TO_NEG  = 2'b10,
    RM_TO_POS  = 2'b11
  } rmode_t;

endpackage

// File: rtl/mrnd_decide.sv
module mrnd_decide
  import mrnd_pkg::*;
(
  input  logic       kept_lsb,
  input  logic       guard_bit,
  input  logic       round_bit,
  input  logic       sticky_bit,
  input  logic       sign_bit,
  input  logic [1:0] mode,
  output logic       bump,
  output logic       lossy
);

  rmode_t mode_e;

  always_comb begin
    mode_e = rmode_t'(mode);
    lossy  = guard_bit | round_bit | sticky_bit;
    bump   = 1'b0;
    if (lossy) begin
      unique case (mode_e)
        RM_NEAREST: bump = guard_bit & (round_bit | sticky_bit | kept_lsb);
        RM_TO_ZERO: bump = 1'b0;
        RM_TO_NEG:  bump = sign_bit;
        RM_TO_POS:  bump = ~sign_bit;
        default:    bump = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/mrnd_incr.sv
module mrnd_incr #(
  parameter int W     = 65,
  parameter int SEG_W = 16
) (
  input  logic         inc,
  input  logic [W-1:0] a,
  output logic [W:0]   sum
);

  localparam int NSEG  = W / SEG_W + 1;
  localparam int PAD_W = NSEG * SEG_W;

  logic [PAD_W-1:0] a_pad;
  logic [PAD_W-1:0] s_pad;
  logic [NSEG:0]    carry;

  assign a_pad    = PAD_W'(a);
  assign carry[0] = inc;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign s_pad[g*SEG_W +: SEG_W] = a_pad[g*SEG_W +: SEG_W] + SEG_W'(carry[g]);
    assign carry[g+1] = carry[g] & (&a_pad[g*SEG_W +: SEG_W]);
  end

  assign sum = s_pad[W:0];

  if (PAD_W > W + 1) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^{s_pad[PAD_W-1:W+1], carry[NSEG]};
  end else begin : g_nospare
    logic unused_spare;
    assign unused_spare = carry[NSEG];
  end

endmodule

// File: rtl/mant_rounder.sv
module mant_rounder #(
  parameter int MANT_W = 67,
  parameter int SEG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic              in_sign,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic [MANT_W-2:0] out_mant,
  output logic              out_round_up,
  output logic              out_inexact
);

  localparam int KEEP_W = MANT_W - 2;
  localparam int OUT_W  = MANT_W - 1;

  logic [KEEP_W-1:0] kept;
  logic [OUT_W-1:0]  rounded;
  logic              bump;
  logic              lossy;

  assign kept = in_mant[MANT_W-1:2];

  mrnd_decide u_decide (
    .kept_lsb   (in_mant[2]),
    .guard_bit  (in_mant[1]),
    .round_bit  (in_mant[0]),
    .sticky_bit (in_sticky),
    .sign_bit   (in_sign),
    .mode       (in_mode),
    .bump       (bump),
    .lossy      (lossy)
  );

  mrnd_incr #(.W(KEEP_W), .SEG_W(SEG_W)) u_incr (
    .inc (bump),
    .a   (kept),
    .sum (rounded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_mant     <= '0;
      out_round_up <= 1'b0;
      out_inexact  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mant     <= rounded;
        out_round_up <= bump;
        out_inexact  <= lossy;
      end
    end
  end

  // R1: result equals kept bits plus the reported increment
  p_sum_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_mant == ({1'b0, $past(in_mant[MANT_W-1:2])} + OUT_W'(out_round_up)));

  // R2: exact operands never round or flag
  p_exact_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mant[1:0] == 2'b00 && !in_sticky) |=> (!out_inexact && !out_round_up));

  // R3: any lost bit flags inexact
  p_lossy_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_mant[1:0] != 2'b00 || in_sticky)) |=> out_inexact);

  // R5: toward zero never increments
  p_tozero_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'b01) |=> !out_round_up);

  // R8: a round-up is only ever reported together with inexact
  p_up_inexact_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_round_up) |-> out_inexact);

  // R9: result strobe follows the operand strobe by one cycle
  p_lat_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_mant) && $stable(out_inexact)));

endmodule

// File: tb/mant_rounder_bench.sv
module mant_rounder_bench;

  localparam int W  = 67;
  localparam int OW = W - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_mant = '0;
  logic          in_sticky = 1'b0;
  logic          in_sign = 1'b0;
  logic [1:0]    in_mode = 2'b00;
  logic          out_valid;
  logic [OW-1:0] out_mant;
  logic          out_round_up;
  logic          out_inexact;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [OW-1:0] q_mant[$];
  logic          q_up[$];
  logic          q_inx[$];
  string         q_tag[$];
  logic [OW-1:0] last_mant = '0;

  always #4 clk = ~clk;

  mant_rounder #(.MANT_W(W), .SEG_W(16)) u_mant_rounder (
    .clk, .rst, .in_valid, .in_mant, .in_sticky, .in_sign, .in_mode,
    .out_valid, .out_mant, .out_round_up, .out_inexact
  );

  function automatic logic model_inc(input logic [W-1:0] m, input logic s,
                                     input logic sg, input logic [1:0] md);
    logic lost;
    lost = m[1] | m[0] | s;
    if (!lost) return 1'b0;
    case (md)
      2'b00:   return m[1] & (m[0] | s | m[2]);
      2'b01:   return 1'b0;
      2'b10:   return sg;
      default: return ~sg;
    endcase
  endfunction

  task automatic send(input logic [W-1:0] m, input logic s, input logic sg,
                      input logic [1:0] md, input string tag);
    logic inc;
    @(negedge clk);
    in_valid  = 1'b1;
    in_mant   = m;
    in_sticky = s;
    in_sign   = sg;
    in_mode   = md;
    inc = model_inc(m, s, sg, md);
    q_mant.push_back({1'b0, m[W-1:2]} + OW'(inc));
    q_up.push_back(inc);
    q_inx.push_back(m[1] | m[0] | s);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [OW-1:0] act, input logic [OW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_mant.size() == 0) begin
        check(1'b0, "R9", "unexpected out_valid", OW'(1), OW'(0));
      end else begin
        logic [OW-1:0] em;
        logic eu, ei;
        string t;
        em = q_mant.pop_front();
        eu = q_up.pop_front();
        ei = q_inx.pop_front();
        t  = q_tag.pop_front();
        check(out_mant == em && out_round_up == eu && out_inexact == ei, t,
              "mant/up/inexact",
              {out_mant[OW-3:0], out_round_up, out_inexact},
              {em[OW-3:0], eu, ei});
        if (out_mant != em)
          $display("     detail %s mant actual=%h expected=%h", t, out_mant, em);
        last_mant = em;
      end
    end
  end

  function automatic logic [W-1:0] mk(input logic [W-3:0] k, input logic [1:0] gr);
    return {k, gr};
  endfunction

  localparam logic [W-3:0] K_EVEN = {1'b1, 64'h0123_4567_89AB_CDE0};
  localparam logic [W-3:0] K_ODD  = {1'b1, 64'h0123_4567_89AB_CDE1};
  localparam logic [W-3:0] K_ONES = '1;
  localparam logic [W-3:0] K_SEG  = {1'b1, 64'h0000_0000_0000_FFFF};

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 0 && out_round_up == 0 && out_inexact == 0, "R10",
          "reset flags", OW'({out_valid, out_round_up, out_inexact}), OW'(0));
    check(out_mant == '0, "R10", "reset mant", out_mant, '0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && out_mant == '0, "R10", "after release", out_mant, '0);

    // R2: exact in every mode and sign
    for (int md = 0; md < 4; md++) begin
      send(mk(K_ODD, 2'b00), 1'b0, 1'b0, 2'(md), "R2");
      send(mk(K_ODD, 2'b00), 1'b0, 1'b1, 2'(md), "R2");
    end
    // R4: nearest, ties to even and above/below half
    send(mk(K_EVEN, 2'b10), 1'b0, 1'b0, 2'b00, "R4");
    send(mk(K_ODD,  2'b10), 1'b0, 1'b0, 2'b00, "R4");
    send(mk(K_EVEN, 2'b11), 1'b0, 1'b1, 2'b00, "R4");
    send(mk(K_EVEN, 2'b10), 1'b1, 1'b0, 2'b00, "R4");
    // R3: inexact below half in nearest, no increment
    send(mk(K_EVEN, 2'b01), 1'b1, 1'b0, 2'b00, "R3");
    send(mk(K_EVEN, 2'b00), 1'b1, 1'b1, 2'b00, "R3");
    // R5: toward zero
    send(mk(K_ODD, 2'b11), 1'b1, 1'b0, 2'b01, "R5");
    send(mk(K_ODD, 2'b11), 1'b1, 1'b1, 2'b01, "R5");
    // R6: toward minus infinity
    send(mk(K_EVEN, 2'b00), 1'b1, 1'b1, 2'b10, "R6");
    send(mk(K_EVEN, 2'b00), 1'b1, 1'b0, 2'b10, "R6");
    // R7: toward plus infinity
    send(mk(K_EVEN, 2'b01), 1'b0, 1'b0, 2'b11, "R7");
    send(mk(K_EVEN, 2'b01), 1'b0, 1'b1, 2'b11, "R7");
    // R1, R8: carry to 2.0 and across a segment boundary
    send(mk(K_ONES, 2'b10), 1'b0, 1'b0, 2'b00, "R1");
    send(mk(K_ONES, 2'b00), 1'b1, 1'b1, 2'b10, "R8");
    send(mk(K_ONES, 2'b01), 1'b0, 1'b0, 2'b11, "R1");
    send(mk(K_SEG,  2'b11), 1'b0, 1'b0, 2'b00, "R8");
    // R9: gap, outputs hold
    idle(3);
    check(out_valid == 0, "R9", "valid low in gap", OW'(out_valid), OW'(0));
    check(out_mant == last_mant, "R9", "mant held in gap", out_mant, last_mant);
    // random operands
    for (int i = 0; i < 60; i++) begin
      send(W'({$urandom, $urandom, $urandom}), 1'($urandom), 1'($urandom),
           2'($urandom), "R1");
      if (i % 7 == 3) idle(1);
    end
    idle(3);
    check(q_mant.size() == 0, "R9", "all results seen", OW'(q_mant.size()), OW'(0));
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule